// File: doc/BRIEF.md
# Clock-Gap Framed Serial Receiver

This block receives a synchronous serial stream from a master that drives clock and data but provides no chip-select. It brings the serial clock, serial data and an optional select line into a fast system clock domain through two-flop synchronizers. It measures how long the serial clock rests at its idle level. Once that rest lasts a programmable number of system-clock cycles, the receiver declares a frame boundary. It ends the running frame and starts the next one there.

Inside a frame, data is sampled on each serial-clock transition that leaves the idle level and collected MSB first into bytes. Each byte is reported with a one-cycle valid strobe, and the first byte of a frame also raises a start marker. A frame boundary raises an end marker when the frame carried any bits. An error flag is raised with it when the bit count was not a whole number of bytes. For older masters, a mode input switches framing to an active-low select line, and the idle-gap timer is then ignored.

The system clock must run at least four times the serial bit rate. The mode input is expected to be static while traffic flows. The default gap threshold is 5 ms worth of system-clock cycles. A master that pauses its clock about 40 ms between frames of roughly 10 ms is therefore resynchronized well before the pause ends.

Top module: `gapser_rx`

## Requirements
- R1: After reset all output strobes are low, and serial bits that arrive before the first frame boundary following reset are discarded: they produce no byte, start or end marker.
- R2: In gap mode, a frame boundary is declared when the synchronized serial clock has stayed at its idle level (high by default) with no transition for GAP_CYCLES consecutive system cycles. The end marker `eof_o` then pulses for one cycle, GAP_CYCLES+3 cycles after the input clock returned to idle.
- R3: Idle intervals inside a frame that are shorter than GAP_CYCLES, between bits or between bytes, do not end the frame. Byte assembly continues across them with no end or start marker.
- R4: Data is sampled on the serial-clock transition leaving the idle level (falling for idle-high), most significant bit first. After the eighth such transition `byte_o` holds the byte and `byte_vld_o` pulses for one cycle, 3 cycles after that transition at the input.
- R5: `sof_o` pulses together with `byte_vld_o` for the first byte after a frame boundary only, and is low with all later bytes of that frame.
- R6: If the bit count at a frame boundary is not a multiple of 8, `part_err_o` pulses in the same cycle as `eof_o`. The leftover bits are dropped, and the next frame starts byte-aligned with a fresh start marker.
- R7: A frame boundary (or, in select mode, a select release) with no bits received since the previous boundary produces no end marker.
- R8: The gap timer saturates: an idle gap many times longer than GAP_CYCLES yields exactly one frame boundary.
- R9: With `legacy_mode_i` high, a frame starts when `ser_sel_n_i` goes low and ends when it goes high. `eof_o` pulses 3 cycles after the select rises at the input. Clock gaps of any length inside the select window do not end the frame, and bits clocked while the select is high are ignored.
- R10: A serial clock held at its non-idle level, for any duration, does not count toward the gap threshold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| legacy_mode_i | input | 1 | 1 selects framing by the select line, 0 by clock idle gaps |
| ser_clk_i | input | 1 | Serial clock from the master (asynchronous) |
| ser_dat_i | input | 1 | Serial data from the master (asynchronous) |
| ser_sel_n_i | input | 1 | Active-low frame select, used in legacy mode |
| byte_o | output | 8 | Last assembled byte |
| byte_vld_o | output | 1 | One-cycle strobe: new byte on byte_o |
| sof_o | output | 1 | One-cycle strobe with the first byte of a frame |
| eof_o | output | 1 | One-cycle strobe at a frame end that carried bits |
| part_err_o | output | 1 | One-cycle strobe with eof_o when the last byte was incomplete |

## Verification
Every result is due a fixed number of system cycles after its stimulus. A byte strobe comes 3 cycles after the input clock leaves idle for the eighth bit: two synchronizer stages and one output register. A gap-mode end marker comes GAP_CYCLES+3 cycles after the last return of the input clock to idle. A select-mode end marker comes 3 cycles after the select rises. The bench drives and samples on the falling system-clock edge and stamps each stimulus and each observed strobe with a cycle counter. Latencies are compared exactly against these sums. Checks that something did not happen are made against event counters after waits that cover the whole window in which it could have happened.

// File: rtl/gapser_pkg.sv
package gapser_pkg;

    localparam int BYTE_W = 8;
    localparam int BIT_W  = $clog2(BYTE_W);

    // Per-cycle receive events reported at the block outputs
    typedef struct packed {
        logic vld;
        logic sof;
        logic eof;
        logic perr;
    } rx_evt_t;

    // True on the sample where the line moves away from its rest level
    function automatic logic leaves_idle(logic prev, logic cur, logic idle);
        return (prev == idle) && (cur != idle);
    endfunction

endpackage

// File: rtl/gapser_sync.sv
module gapser_sync #(
    parameter int             W       = 1,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= RST_VAL;
            sync_o <= RST_VAL;
        end else begin
            stage1 <= async_i;
            sync_o <= stage1;
        end
    end
endmodule

// File: rtl/gapser_gap.sv
module gapser_gap #(
    parameter int   GAP_CYCLES = 1000,
    parameter logic IDLE_LEVEL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic sclk_s,
    input  logic sclk_edge,
    output logic hit_o
);
    localparam int           CW     = $clog2(GAP_CYCLES + 1);
    localparam logic [CW-1:0] GAP_V = CW'(GAP_CYCLES);
    localparam logic [CW-1:0] GAP_M1 = CW'(GAP_CYCLES - 1);

    logic [CW-1:0] cnt;
    logic          resting;

    assign resting = !sclk_edge && (sclk_s == IDLE_LEVEL);
    assign hit_o   = resting && (cnt == GAP_M1);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (!resting) begin
            cnt <= '0;
        end else if (cnt != GAP_V) begin
            cnt <= cnt + 1'b1;
        end
    end

    p_hit_single_r2: assert property (@(posedge clk) disable iff (rst)
        hit_o |=> !hit_o);

    p_cnt_bound_r8: assert property (@(posedge clk) disable iff (rst)
        cnt <= GAP_V);

    p_busy_clears_r10: assert property (@(posedge clk) disable iff (rst)
        (sclk_s != IDLE_LEVEL) |=> (cnt == '0));
endmodule

// File: rtl/gapser_asm.sv
module gapser_asm
    import gapser_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start_ev,
    input  logic              end_ev,
    input  logic              sample_ev,
    input  logic              bit_i,
    output logic [BYTE_W-1:0] byte_o,
    output rx_evt_t           evt_o
);
    localparam logic [BIT_W-1:0] LAST_POS = BIT_W'(BYTE_W - 1);

    logic [BYTE_W-2:0] shreg;
    logic [BIT_W-1:0]  bitpos;
    logic              any_bits;
    logic              first;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg    <= '0;
            bitpos   <= '0;
            any_bits <= 1'b0;
            first    <= 1'b0;
            byte_o   <= '0;
            evt_o    <= '0;
        end else begin
            evt_o <= '0;
            if (end_ev && any_bits) begin
                evt_o.eof  <= 1'b1;
                evt_o.perr <= (bitpos != '0);
            end
            if (start_ev || end_ev) begin
                bitpos   <= '0;
                any_bits <= 1'b0;
                first    <= start_ev;
            end else if (sample_ev) begin
                shreg    <= {shreg[BYTE_W-3:0], bit_i};
                any_bits <= 1'b1;
                bitpos   <= bitpos + 1'b1;
                if (bitpos == LAST_POS) begin
                    byte_o    <= {shreg, bit_i};
                    evt_o.vld <= 1'b1;
                    evt_o.sof <= first;
                    first     <= 1'b0;
                end
            end
        end
    end

    p_sof_with_vld_r5: assert property (@(posedge clk) disable iff (rst)
        evt_o.sof |-> evt_o.vld);

    p_perr_with_eof_r6: assert property (@(posedge clk) disable iff (rst)
        evt_o.perr |-> evt_o.eof);

    p_eof_needs_bits_r7: assert property (@(posedge clk) disable iff (rst)
        (end_ev && !any_bits) |=> !evt_o.eof);
endmodule

// File: rtl/gapser_rx.sv
module gapser_rx
    import gapser_pkg::*;
#(
    parameter int   CLK_HZ     = 200_000_000,
    parameter int   GAP_US     = 5000,
    parameter int   GAP_CYCLES = (CLK_HZ / 1_000_000) * GAP_US,
    parameter logic IDLE_LEVEL = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              legacy_mode_i,
    input  logic              ser_clk_i,
    input  logic              ser_dat_i,
    input  logic              ser_sel_n_i,
    output logic [BYTE_W-1:0] byte_o,
    output logic              byte_vld_o,
    output logic              sof_o,
    output logic              eof_o,
    output logic              part_err_o
);
    localparam logic [2:0] SYNC_RST = {1'b1, 1'b0, IDLE_LEVEL};

    logic [2:0] sync_v;
    logic       sclk_s, dat_s, sel_s;
    logic       sclk_q, sel_q;
    logic       sclk_edge, leave_ev;
    logic       sel_fall, sel_rise;
    logic       gap_hit;
    logic       start_ev, end_ev, sample_ev;
    logic       framed;
    rx_evt_t    evt;

    gapser_sync #(.W(3), .RST_VAL(SYNC_RST)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i ({ser_sel_n_i, ser_dat_i, ser_clk_i}),
        .sync_o  (sync_v)
    );

    assign sclk_s = sync_v[0];
    assign dat_s  = sync_v[1];
    assign sel_s  = sync_v[2];

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q <= IDLE_LEVEL;
            sel_q  <= 1'b1;
        end else begin
            sclk_q <= sclk_s;
            sel_q  <= sel_s;
        end
    end

    assign sclk_edge = sclk_s ^ sclk_q;
    assign leave_ev  = leaves_idle(sclk_q, sclk_s, IDLE_LEVEL);
    assign sel_fall  = sel_q && !sel_s;
    assign sel_rise  = !sel_q && sel_s;

    gapser_gap #(.GAP_CYCLES(GAP_CYCLES), .IDLE_LEVEL(IDLE_LEVEL)) u_gap (
        .clk       (clk),
        .rst       (rst),
        .sclk_s    (sclk_s),
        .sclk_edge (sclk_edge),
        .hit_o     (gap_hit)
    );

    assign start_ev  = legacy_mode_i ? sel_fall : gap_hit;
    assign end_ev    = legacy_mode_i ? sel_rise : gap_hit;
    assign sample_ev = leave_ev && framed;

    always_ff @(posedge clk) begin
        if (rst) begin
            framed <= 1'b0;
        end else if (start_ev) begin
            framed <= 1'b1;
        end else if (end_ev) begin
            framed <= 1'b0;
        end
    end

    gapser_asm u_asm (
        .clk       (clk),
        .rst       (rst),
        .start_ev  (start_ev),
        .end_ev    (end_ev),
        .sample_ev (sample_ev),
        .bit_i     (dat_s),
        .byte_o    (byte_o),
        .evt_o     (evt)
    );

    assign byte_vld_o = evt.vld;
    assign sof_o      = evt.sof;
    assign eof_o      = evt.eof;
    assign part_err_o = evt.perr;

    p_vld_framed_r1: assert property (@(posedge clk) disable iff (rst)
        byte_vld_o |-> $past(framed));

    p_legacy_eof_r9: assert property (@(posedge clk) disable iff (rst)
        (legacy_mode_i && $past(legacy_mode_i) && eof_o) |-> $past(sel_rise));
endmodule

// File: tb/gapser_rx_bench.sv
module gapser_rx_bench;
    localparam int GAP  = 40;
    localparam int HALF = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       legacy = 1'b0;
    logic       sclk = 1'b1;
    logic       sdat = 1'b0;
    logic       seln = 1'b1;
    logic [7:0] byte_o;
    logic       byte_vld_o, sof_o, eof_o, part_err_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int fall_cyc = 0;
    int rise_cyc = 0;
    bit done = 1'b0;

    // Event log filled by the monitor
    logic [7:0] rx_b [64];
    logic       rx_s [64];
    int         rx_c [64];
    int nrx = 0, nsof = 0, neof = 0, nperr = 0, eof_c = 0;

    always #2.5 clk = ~clk;

    gapser_rx #(.GAP_CYCLES(GAP)) u_gapser_rx (
        .clk           (clk),
        .rst           (rst),
        .legacy_mode_i (legacy),
        .ser_clk_i     (sclk),
        .ser_dat_i     (sdat),
        .ser_sel_n_i   (seln),
        .byte_o        (byte_o),
        .byte_vld_o    (byte_vld_o),
        .sof_o         (sof_o),
        .eof_o         (eof_o),
        .part_err_o    (part_err_o)
    );

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (!rst) begin
            if (byte_vld_o && nrx < 64) begin
                rx_b[nrx] = byte_o;
                rx_s[nrx] = sof_o;
                rx_c[nrx] = cyc;
                nrx++;
            end
            if (sof_o) nsof++;
            if (eof_o) begin
                neof++;
                eof_c = cyc;
            end
            if (part_err_o) nperr++;
        end
    end

    task automatic check(string req, int act, int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic send_bit(logic b);
        @(negedge clk);
        sdat = b;
        @(negedge clk);
        sclk = 1'b0;
        fall_cyc = cyc;
        repeat (HALF) @(negedge clk);
        sclk = 1'b1;
        rise_cyc = cyc;
        repeat (HALF - 1) @(negedge clk);
    endtask

    task automatic send_byte(logic [7:0] v);
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (4) @(negedge clk);
        check("R1 reset strobes", {byte_vld_o, sof_o, eof_o, part_err_o}, 0);
        rst = 1'b0;
        send_byte(8'hFF);   // before the first boundary: discarded
        idle(GAP + 10);
        check("R1 pre-sync bytes", nrx, 0);
        check("R1 pre-sync eof", neof, 0);
    endtask

    task automatic t_basic;
        int b0 = nrx;
        int e0 = neof;
        send_byte(8'hA5);
        idle(20);           // inter-byte rest shorter than the gap
        send_byte(8'h3C);
        idle(4);
        check("R3 no eof inside frame", neof, e0);
        check("R4 byte count", nrx - b0, 2);
        check("R4 first byte MSB first", rx_b[b0], 8'hA5);
        check("R4 second byte", rx_b[b0+1], 8'h3C);
        check("R4 byte_vld latency", rx_c[b0+1], fall_cyc + 3);
        check("R5 sof on first byte", rx_s[b0], 1);
        check("R3 R5 no sof on second byte", rx_s[b0+1], 0);
        idle(GAP + 10);
        check("R2 one eof", neof - e0, 1);
        check("R2 eof latency", eof_c, rise_cyc + GAP + 3);
        check("R2 no part_err on whole bytes", nperr, 0);
    endtask

    task automatic t_partial;
        int b0 = nrx;
        int e0 = neof;
        int p0 = nperr;
        send_byte(8'h5A);
        send_bit(1'b1);
        send_bit(1'b0);
        send_bit(1'b1);
        idle(GAP + 10);
        check("R6 whole byte kept", rx_b[b0], 8'h5A);
        check("R6 eof", neof - e0, 1);
        check("R6 part_err", nperr - p0, 1);
        send_byte(8'h81);
        idle(GAP + 10);
        check("R6 realigned byte", rx_b[b0+1], 8'h81);
        check("R6 fresh sof", rx_s[b0+1], 1);
        check("R6 no part_err on clean frame", nperr - p0, 1);
    endtask

    task automatic t_longgap;
        int e0 = neof;
        int s0 = nsof;
        idle(3 * GAP);
        check("R8 R7 no extra eof in long gap", neof, e0);
        check("R8 no extra sof", nsof, s0);
    endtask

    task automatic t_stuck;
        int b0 = nrx;
        int e0 = neof;
        int fc, rc;
        for (int i = 0; i < 7; i++) send_bit(i >= 4);
        @(negedge clk);
        sdat = 1'b1;
        @(negedge clk);
        sclk = 1'b0;
        fc = cyc;
        idle(3 * GAP);
        check("R10 no eof while clock held busy", neof, e0);
        check("R10 byte before stall", rx_b[b0], 8'h0F);
        check("R4 byte_vld at eighth edge", rx_c[b0], fc + 3);
        @(negedge clk);
        sclk = 1'b1;
        rc = cyc;
        idle(GAP + 10);
        check("R10 R2 eof after release", eof_c, rc + GAP + 3);
    endtask

    task automatic t_legacy;
        int b0, e0, sc;
        legacy = 1'b1;
        idle(5);
        b0 = nrx;
        e0 = neof;
        @(negedge clk);
        seln = 1'b0;
        idle(4);
        for (int i = 0; i < 4; i++) send_bit(i < 2);
        idle(3 * GAP);      // clock gap well past threshold inside select window
        for (int i = 0; i < 4; i++) send_bit(i >= 2);
        idle(4);
        check("R9 gap ignored in select mode", neof, e0);
        check("R9 byte across gap", rx_b[b0], 8'hC3);
        check("R9 sof in select mode", rx_s[b0], 1);
        @(negedge clk);
        seln = 1'b1;
        sc = cyc;
        idle(6);
        check("R9 eof on select release", neof - e0, 1);
        check("R9 eof latency", eof_c, sc + 3);
        send_byte(8'h77);   // select inactive: ignored
        idle(6);
        check("R9 bits outside select ignored", nrx - b0, 1);
        e0 = neof;
        @(negedge clk);
        seln = 1'b0;
        idle(5);
        seln = 1'b1;
        idle(6);
        check("R7 empty select window no eof", neof, e0);
    endtask

    initial begin
        t_reset();
        t_basic();
        t_partial();
        t_longgap();
        t_stuck();
        t_legacy();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule